// File: doc/BRIEF.md
# Shift and Rotate Unit

This unit moves the bits of an n-bit operand by a count taken from an immediate field. It works alongside a separate carry flag and covers seven operations: logical shifts in both directions, an arithmetic right shift, plain rotates in both directions, and rotates in both directions that pass through the carry. The whole move by the given count happens in one operation.

The carry flag always ends up holding the last bit that left the operand. This rule also covers plain rotates, where the bit wraps to the other end and a copy of it goes to the carry. For the rotates through carry, the flag and the operand form one ring of n+1 bits.

The unit is purely combinational. Its result and carry-out follow the inputs in the same cycle and hold no state. No data is stored, so a stream handshake would add nothing here. The interface has no valid/ready pair and no back-pressure. A surrounding datapath registers the outputs wherever it needs to.

Top module: `shr_unit`

## Requirements
- R1: When the count is zero, the result equals the operand and the carry-out equals the carry-in, for every operation code.
- R2: Operation code 0 shifts left. Zeros enter at bit 0, and the carry-out is the last bit that leaves bit n-1. That bit is the operand bit at position n-k for a count k of 1 to n. A count above n gives a zero result and a zero carry.
- R3: Operation code 1 shifts right logically. Zeros enter at bit n-1, and the carry-out is operand bit k-1 for a count k of 1 to n. A count above n gives a zero result and a zero carry.
- R4: Operation code 2 shifts right arithmetically. Copies of operand bit n-1 fill the vacated top bits, and the carry-out is operand bit k-1. For a count above n, the result and the carry both equal the sign bit.
- R5: Operation codes 3 (rotate left) and 4 (rotate right) wrap bits end to end, and the count is taken modulo n. For a nonzero count, the carry-out equals result bit 0 after a left rotate and result bit n-1 after a right rotate.
- R6: Operation codes 5 (left) and 6 (right) rotate the ring formed by the carry-in above bit n-1 of the operand. The count is taken modulo n+1, and the carry-out is the ring bit above the result.
- R7: A logical shift by exactly n gives a zero result. The carry-out is then the far end bit: operand bit 0 for a left shift and operand bit n-1 for a right shift. An arithmetic right shift by n gives all sign bits, with operand bit n-1 as the carry.
- R8: Operation code 7 is a pass-through. It returns the operand and the carry-in unchanged for any count.
- R9: The outputs depend only on the present inputs. They are valid within the same cycle in which the inputs change, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | WIDTH | Operand to be shifted or rotated |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 3 | Operation code (0..7, see R2 to R8) |
| count_i | input | CNT_W | Immediate count, CNT_W = clog2(WIDTH+2) |
| res_o | output | WIDTH | Shifted or rotated value |
| carry_o | output | 1 | New carry flag |

## Verification
Every time the inputs settle, the bound checker confirms several structural facts. A zero count and the pass-through code leave the operand and carry untouched. A left shift clears its low bits, and a right logical shift by n or more gives zero. An arithmetic shift keeps the sign. Rotates keep the count of set bits, with the ring counted as n+1 bits for the through-carry forms, and the carry of a plain rotate copies the end bit that just wrapped. Only the bench can show that each bit lands in the exact position and that the carry picks the correct departing bit. It does this by comparing every output against a step-by-step model, which covers counts reduced modulo the ring size and counts above the register width.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    SH_LSL  = 3'd0,
    SH_LSR  = 3'd1,
    SH_ASR  = 3'd2,
    SH_ROL  = 3'd3,
    SH_ROR  = 3'd4,
    SH_RCL  = 3'd5,
    SH_RCR  = 3'd6,
    SH_PASS = 3'd7
  } shr_op_e;
endpackage

// File: rtl/shr_barrel_rs.sv
// Logarithmic right shifter: one mux stage per amount bit.
module shr_barrel_rs #(
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] amt,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stage [0:SW];

  assign stage[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] >> (2 ** s)) : stage[s];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/shr_linear_shift.sv
// Right shift with a programmable fill bit and a guard bit that
// catches the last bit leaving the bottom end.
module shr_linear_shift #(
  parameter int N  = 16,
  parameter int CW = 5
) (
  input  logic [N-1:0]  din,
  input  logic          fill,
  input  logic [CW-1:0] amt,      // already clamped to at most N+1
  output logic [N-1:0]  dout,
  output logic          last_out
);
  localparam int DW = 2 * N + 2;
  localparam int SW = $clog2(DW);

  logic [DW-1:0] wide;
  logic [DW-1:0] shifted;
  logic [SW-1:0] amt_x;

  assign wide  = {{(N+1){fill}}, din, 1'b0};
  assign amt_x = SW'(amt);

  shr_barrel_rs #(.DW(DW), .SW(SW)) u_bar (
    .din  (wide),
    .amt  (amt_x),
    .dout (shifted)
  );

  assign dout     = shifted[N:1];
  assign last_out = shifted[0];
endmodule

// File: rtl/shr_ring_rotate.sv
// Rotates an R-bit ring in either direction; the count is reduced modulo R.
module shr_ring_rotate #(
  parameter int R  = 16,
  parameter int CW = 5
) (
  input  logic [R-1:0]  din,
  input  logic [CW-1:0] amt,
  input  logic          left,
  output logic [R-1:0]  dout
);
  localparam int DW = 2 * R;
  localparam int SW = $clog2(DW);

  int            red;
  logic [SW-1:0] ramt;
  logic [DW-1:0] shifted;

  always_comb begin
    red = int'(amt) % R;
    if (left && red != 0) red = R - red;
    ramt = SW'(red);
  end

  shr_barrel_rs #(.DW(DW), .SW(SW)) u_bar (
    .din  ({din, din}),
    .amt  (ramt),
    .dout (shifted)
  );

  assign dout = shifted[R-1:0];
endmodule

// File: rtl/shr_unit.sv
module shr_unit #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 2)
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             carry_i,
  input  logic [2:0]       op_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  import shr_pkg::*;

  localparam logic [CNT_W-1:0] LIN_MAX = CNT_W'(WIDTH + 1);

  function automatic logic [WIDTH-1:0] bit_rev(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  shr_op_e          op;
  logic             go_left;
  logic             lin_fill;
  logic [CNT_W-1:0] lin_amt;
  logic [WIDTH-1:0] lin_in, lin_res, lin_out;
  logic             lin_co;
  logic [WIDTH-1:0] rot_res;
  logic [WIDTH:0]   rcx_res;

  assign op       = shr_op_e'(op_i);
  assign go_left  = (op == SH_LSL);
  assign lin_fill = (op == SH_ASR) ? opnd_i[WIDTH-1] : 1'b0;
  assign lin_amt  = (count_i > LIN_MAX) ? LIN_MAX : count_i;
  assign lin_in   = go_left ? bit_rev(opnd_i) : opnd_i;
  assign lin_out  = go_left ? bit_rev(lin_res) : lin_res;

  shr_linear_shift #(.N(WIDTH), .CW(CNT_W)) u_lin (
    .din      (lin_in),
    .fill     (lin_fill),
    .amt      (lin_amt),
    .dout     (lin_res),
    .last_out (lin_co)
  );

  shr_ring_rotate #(.R(WIDTH), .CW(CNT_W)) u_rot (
    .din  (opnd_i),
    .amt  (count_i),
    .left (op == SH_ROL),
    .dout (rot_res)
  );

  shr_ring_rotate #(.R(WIDTH + 1), .CW(CNT_W)) u_rcx (
    .din  ({carry_i, opnd_i}),
    .amt  (count_i),
    .left (op == SH_RCL),
    .dout (rcx_res)
  );

  always_comb begin
    res_o   = opnd_i;
    carry_o = carry_i;
    if (count_i != '0) begin
      case (op)
        SH_LSL, SH_LSR, SH_ASR: begin
          res_o   = lin_out;
          carry_o = lin_co;
        end
        SH_ROL: begin
          res_o   = rot_res;
          carry_o = rot_res[0];
        end
        SH_ROR: begin
          res_o   = rot_res;
          carry_o = rot_res[WIDTH-1];
        end
        SH_RCL, SH_RCR: begin
          res_o   = rcx_res[WIDTH-1:0];
          carry_o = rcx_res[WIDTH];
        end
        default: begin
          res_o   = opnd_i;
          carry_o = carry_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 2)
) (
  input logic [WIDTH-1:0] opnd_i,
  input logic             carry_i,
  input logic [2:0]       op_i,
  input logic [CNT_W-1:0] count_i,
  input logic [WIDTH-1:0] res_o,
  input logic             carry_o
);
  logic low_clear;

  always_comb begin
    low_clear = 1'b1;
    for (int i = 0; i < WIDTH; i++)
      if (i < int'(count_i) && res_o[i]) low_clear = 1'b0;
  end

  always_comb begin
    if (count_i == '0) begin
      p_zero_keeps_r1: assert (res_o == opnd_i && carry_o == carry_i)
        else $error("zero count changed state");
    end
    if (op_i == 3'd7) begin
      p_pass_code_r8: assert (res_o == opnd_i && carry_o == carry_i)
        else $error("pass-through code altered state");
    end
    if (op_i == 3'd0) begin
      p_left_low_zero_r2: assert (low_clear)
        else $error("left shift left nonzero low bits");
    end
    if (op_i == 3'd1 && int'(count_i) >= WIDTH) begin
      p_right_all_out_r7: assert (res_o == '0)
        else $error("logical right by width not zero");
    end
    if (op_i == 3'd2) begin
      p_sign_kept_r4: assert (res_o[WIDTH-1] == opnd_i[WIDTH-1])
        else $error("arithmetic shift lost sign");
    end
    if (op_i == 3'd3 || op_i == 3'd4) begin
      p_rot_ones_r5: assert ($countones(res_o) == $countones(opnd_i))
        else $error("rotate changed population");
    end
    if (op_i == 3'd3 && count_i != '0) begin
      p_rol_carry_r5: assert (carry_o == res_o[0])
        else $error("rotate-left carry not wrapped bit");
    end
    if (op_i == 3'd5 || op_i == 3'd6) begin
      p_ring_ones_r6: assert ($countones({carry_o, res_o}) == $countones({carry_i, opnd_i}))
        else $error("carry ring changed population");
    end
  end
endmodule

bind shr_unit shr_unit_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .opnd_i  (opnd_i),
  .carry_i (carry_i),
  .op_i    (op_i),
  .count_i (count_i),
  .res_o   (res_o),
  .carry_o (carry_o)
);

// File: tb/sim_shr_unit.sv
`timescale 1ns/1ps
module sim_shr_unit;
  localparam int N  = 16;
  localparam int CW = $clog2(N + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  opnd;
  logic          cin;
  logic [2:0]    op;
  logic [CW-1:0] cnt;
  logic [N-1:0]  res;
  logic          cout;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  shr_unit #(.WIDTH(N), .CNT_W(CW)) u0 (
    .opnd_i  (opnd),
    .carry_i (cin),
    .op_i    (op),
    .count_i (cnt),
    .res_o   (res),
    .carry_o (cout)
  );

  // Behavioural model: one single-bit step per unit of count.
  function automatic void model(input logic [N-1:0] a, input logic c,
                                input int opc, input int k,
                                output logic [N-1:0] r, output logic co);
    logic t;
    r  = a;
    co = c;
    if (opc == 7) return;
    for (int i = 0; i < k; i++) begin
      case (opc)
        0: begin co = r[N-1]; r = {r[N-2:0], 1'b0}; end
        1: begin co = r[0];   r = {1'b0, r[N-1:1]}; end
        2: begin co = r[0];   r = {r[N-1], r[N-1:1]}; end
        3: begin co = r[N-1]; r = {r[N-2:0], r[N-1]}; end
        4: begin co = r[0];   r = {r[0], r[N-1:1]}; end
        5: begin t = r[N-1];  r = {r[N-2:0], co}; co = t; end
        default: begin t = r[0]; r = {co, r[N-1:1]}; co = t; end
      endcase
    end
  endfunction

  function automatic string pick_tag(input int opc, input int k);
    if (k == 0)                  return "R1";
    if (opc == 7)                return "R8";
    if (opc <= 2 && k == N)      return "R7";
    case (opc)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [N-1:0] a, input logic c, input int opc,
                       input int k, input string tag_in);
    logic [N-1:0] er;
    logic         ec;
    string        tag;
    @(negedge clk);
    opnd = a; cin = c; op = 3'(opc); cnt = CW'(k);
    #1;
    model(a, c, opc, k, er, ec);
    tag = (tag_in == "") ? pick_tag(opc, k) : tag_in;
    n_checks++;
    if (res !== er || cout !== ec) begin
      n_errors++;
      $display("FAIL %s op=%0d cnt=%0d a=%h cin=%0b: got res=%h c=%0b, want res=%h c=%0b",
               tag, opc, k, a, c, res, cout, er, ec);
    end
  endtask

  initial begin
    opnd = 16'hA5C3; cin = 1'b1; op = 3'd0; cnt = '0;
    repeat (3) @(posedge clk);
    // Reset state: zero count is transparent (R1)
    apply(16'hA5C3, 1'b1, 0, 0, "R1");
    rst_n = 1'b1;
    @(posedge clk);

    apply(16'h3C0F, 1'b0, 0, 2, "R2");
    apply(16'h8001, 1'b0, 0, 1, "R2");
    apply(16'h3C0F, 1'b1, 1, 2, "R3");
    apply(16'hF00D, 1'b0, 2, 2, "R4");
    apply(16'h700D, 1'b1, 2, 3, "R4");
    apply(16'h8000, 1'b0, 2, 20, "R4");
    apply(16'hC003, 1'b0, 3, 2, "R5");
    apply(16'hC003, 1'b0, 4, 2, "R5");
    apply(16'h1234, 1'b0, 3, 17, "R5");
    apply(16'h1234, 1'b1, 4, N, "R5");
    apply(16'h8001, 1'b0, 5, 2, "R6");
    apply(16'h8001, 1'b1, 6, 2, "R6");
    apply(16'h5A5A, 1'b1, 5, N + 1, "R6");
    apply(16'h5A5A, 1'b0, 6, 20, "R6");
    apply(16'h0001, 1'b0, 0, N, "R7");
    apply(16'h8000, 1'b0, 1, N, "R7");
    apply(16'h8000, 1'b0, 2, N, "R7");
    apply(16'hFFFF, 1'b1, 0, 31, "R2");
    apply(16'hFFFF, 1'b1, 1, 31, "R3");
    apply(16'hBEEF, 1'b0, 7, 5, "R8");
    for (int o = 0; o < 8; o++) apply(16'h6D29, o[0], o, 0, "R1");
    // Same-cycle response (R9): inputs changed and sampled 1 ns later
    apply(16'h0F0F, 1'b1, 6, 3, "R9");

    for (int i = 0; i < 3000; i++)
      apply(N'($urandom), 1'($urandom), int'($urandom_range(0, 7)),
            int'($urandom_range(0, (1 << CW) - 1)), "");

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule